// File: doc/BRIEF.md
# Timestamp Target Comparator

This block watches a free-running time value made of a seconds word and a nanoseconds word. It raises a single event when that time first reaches or passes a target that software has loaded into two words of the same shape. Software arms the comparator with a write to the arm bit. Hardware disarms it on the first hit, so every further event needs a fresh arm.

Each event does three things. It drives a pulse on the hit output for one clock. It sets a sticky status flag. That flag stays set until software writes a clear, and it drives the interrupt line whenever the interrupt enable is high. The comparison tests for greater-than-or-equal rather than exact equality. A timebase that steps over the target in one jump, or is corrected past it, therefore still produces the event.

Top module: `ts_target_cmp`

## Requirements
- R1: After reset the block is disarmed, and hit, status and interrupt are all low.
- R2: A clock edge with arm_wr high loads arm_wdata into the armed state: 1 arms and 0 disarms. The new state is visible on armed after that edge.
- R3: While disarmed, no hit is produced and status does not change, whatever the time value.
- R4: When armed and the 64-bit value {seconds, nanoseconds} is greater than or equal to {target seconds, target nanoseconds} at a clock edge, hit goes high for the following cycle and armed goes low at the same edge. This includes a time that jumps from below the target to above it.
- R5: Hit is high for exactly one clock per event, even if the time stays at or beyond the target.
- R6: Seconds are the more significant word. A time with fewer seconds than the target produces no hit, whatever its nanoseconds.
- R7: An event sets the status flag, and the flag stays set across later cycles until it is cleared.
- R8: A clock edge with sts_clr high clears status. If an event occurs at the same edge, status ends up set.
- R9: The interrupt is high exactly when status and irq_en are both high.
- R10: After an event, no further hit occurs until the block is re-armed. A re-arm while the time is already past the target fires at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| now_sec | input | 32 | Live time, seconds word |
| now_ns | input | 32 | Live time, nanoseconds word |
| tgt_sec | input | 32 | Target, seconds word |
| tgt_ns | input | 32 | Target, nanoseconds word |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Value written to the arm bit |
| sts_clr | input | 1 | Write-one-to-clear strobe for status |
| irq_en | input | 1 | Interrupt enable |
| hit | output | 1 | One-clock event pulse |
| armed | output | 1 | Current arm state |
| sts | output | 1 | Sticky event status |
| irq | output | 1 | Interrupt request |

## Verification
A stuck armed bit would show up as a second hit one clock after the first. A lost arm would show up as a missing hit at the first edge where the time reaches the target. Both are therefore visible within one cycle of the relevant edge. A wrong status register would show as an event that fails to raise the flag, or as a flag that drops without a clear, and the interrupt output reflects either at once. The bench puts the time just below the target, exactly on it, far beyond it, and split across the word boundary, so that a wrong word order or a strict comparison misses at a known edge.

// File: rtl/ts_target_cmp.sv
module ts_target_cmp #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] now_sec,
  input  logic [NS_W-1:0]  now_ns,
  input  logic [SEC_W-1:0] tgt_sec,
  input  logic [NS_W-1:0]  tgt_ns,
  input  logic             arm_wr,
  input  logic             arm_wdata,
  input  logic             sts_clr,
  input  logic             irq_en,
  output logic             hit,
  output logic             armed,
  output logic             sts,
  output logic             irq
);
  localparam int TW = SEC_W + NS_W;

  logic [TW-1:0] now_t, tgt_t;
  logic          reached, fire;

  assign now_t   = {now_sec, now_ns};
  assign tgt_t   = {tgt_sec, tgt_ns};
  assign reached = now_t >= tgt_t;
  assign fire    = armed & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      hit   <= 1'b0;
      sts   <= 1'b0;
    end else begin
      hit <= fire;
      if (fire)        armed <= 1'b0;
      else if (arm_wr) armed <= arm_wdata;
      if (fire)         sts <= 1'b1;
      else if (sts_clr) sts <= 1'b0;
    end
  end

  assign irq = sts & irq_en;
endmodule

module ts_target_cmp_chk (
  input logic clk,
  input logic rst_n,
  input logic hit,
  input logic armed,
  input logic sts,
  input logic sts_clr,
  input logic irq,
  input logic irq_en
);
  a_r4_hit_disarms: assert property (@(posedge clk) disable iff (!rst_n) hit |-> !armed);
  a_r5_one_clock:   assert property (@(posedge clk) disable iff (!rst_n) hit |=> !hit);
  a_r3_idle_quiet:  assert property (@(posedge clk) disable iff (!rst_n) !armed |=> !hit);
  a_r7_hit_sets:    assert property (@(posedge clk) disable iff (!rst_n) hit |-> sts);
  a_r8_sticky:      assert property (@(posedge clk) disable iff (!rst_n) (sts && !sts_clr) |=> sts);
  a_r9_irq_gated:   assert property (@(posedge clk) disable iff (!rst_n) irq |-> (sts && irq_en));
endmodule

bind ts_target_cmp ts_target_cmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .armed(armed), .sts(sts),
  .sts_clr(sts_clr), .irq(irq), .irq_en(irq_en)
);

// File: tb/ts_target_cmp_tb.sv
module ts_target_cmp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] now_sec = '0, now_ns = '0, tgt_sec = '0, tgt_ns = '0;
  logic        arm_wr = 1'b0, arm_wdata = 1'b0, sts_clr = 1'b0, irq_en = 1'b0;
  logic        hit, armed, sts, irq;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ts_target_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns),
    .tgt_sec(tgt_sec), .tgt_ns(tgt_ns), .arm_wr(arm_wr), .arm_wdata(arm_wdata),
    .sts_clr(sts_clr), .irq_en(irq_en), .hit(hit), .armed(armed), .sts(sts), .irq(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic set_time(input int s, input int ns); now_sec = s; now_ns = ns; endtask

  task automatic do_arm(input logic v);
    arm_wr = 1'b1; arm_wdata = v; tick(); arm_wr = 1'b0;
  endtask

  task automatic clr_sts();
    sts_clr = 1'b1; tick(); sts_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 armed", armed, 1'b0); chk("R1 hit", hit, 1'b0);
    chk("R1 sts", sts, 1'b0);     chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_unarmed();
    tgt_sec = 10; tgt_ns = 500; set_time(11, 0);
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R3 hit", hit, 1'b0); chk("R3 sts", sts, 1'b0);
    end
  endtask

  task automatic t_fire_equal();
    set_time(10, 499);
    do_arm(1'b1); chk("R2 armed", armed, 1'b1);
    tick(); chk("R4 below", hit, 1'b0); chk("R4 still armed", armed, 1'b1);
    set_time(10, 500); tick();
    chk("R4 hit on equal", hit, 1'b1); chk("R4 disarmed", armed, 1'b0);
    chk("R7 sts set", sts, 1'b1);
    tick(); chk("R5 single pulse", hit, 1'b0);
    tick(); chk("R7 sticky", sts, 1'b1);
  endtask

  task automatic t_order_jump_rearm();
    clr_sts(); chk("R8 cleared", sts, 1'b0);
    tgt_sec = 20; tgt_ns = 100; set_time(19, 999999999);
    do_arm(1'b1); tick(); chk("R6 low seconds", hit, 1'b0);
    set_time(21, 0); tick(); chk("R4 jump over", hit, 1'b1);
    tick(); chk("R5 past target", hit, 1'b0);
    tick(); chk("R10 no refire", hit, 1'b0);
    do_arm(1'b1); chk("R10 rearmed", armed, 1'b1); chk("R10 not yet", hit, 1'b0);
    tick(); chk("R10 fires after rearm", hit, 1'b1);
  endtask

  task automatic t_disarm();
    clr_sts();
    tgt_sec = 30; tgt_ns = 0; set_time(29, 0);
    do_arm(1'b1); do_arm(1'b0); chk("R2 disarmed", armed, 1'b0);
    set_time(31, 0); tick(); tick();
    chk("R2 no hit", hit, 1'b0); chk("R3 sts unchanged", sts, 1'b0);
  endtask

  task automatic t_set_wins();
    tgt_sec = 40; tgt_ns = 0; set_time(39, 0);
    do_arm(1'b1);
    set_time(40, 7); sts_clr = 1'b1; tick(); sts_clr = 1'b0;
    chk("R8 set wins hit", hit, 1'b1); chk("R8 set wins sts", sts, 1'b1);
  endtask

  task automatic t_irq();
    irq_en = 1'b0; #1 chk("R9 masked", irq, 1'b0);
    irq_en = 1'b1; #1 chk("R9 enabled", irq, 1'b1);
    tick(); clr_sts(); chk("R9 cleared", irq, 1'b0);
    irq_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick(); t_reset();
    rst_n = 1'b1; tick(); t_reset();
    t_unarmed();
    t_fire_equal();
    t_order_jump_rearm();
    t_disarm();
    t_set_wins();
    t_irq();
    finish_run();
  end
endmodule